// File: doc/BRIEF.md
# Banked GPIO Register Interface

A memory-mapped register block that controls 128 general-purpose pins, grouped as four banks of 32. Pin n lives in bank n>>5 at bit n&31. Software reaches the block through a simple request bus: each request carries an address, a write flag and a 32-bit word. Read data and an error flag come back on the cycle after the request. The block decodes a 512-byte window into per-bank registers. It holds the direction, the output latch, the two edge-enable masks and two alternate-function words for each bank. From these it drives the pin outputs and their enables.

Outputs can be changed only through separate set and clear registers. A level read merges the driven value and the sampled input for each pin, choosing per pin by its direction bit. The edge-detection logic sits outside this block. This block passes it the edge-enable masks, a per-bank strobe on each status read, and a one-cycle clear mask on each status write. The status bits that the outside logic holds are read back through this block.

The alternate-function words are storage only. The map is irregular: banks 0 to 2 are packed together at the bottom of the window, and bank 3 repeats the same layout 0x100 higher.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every direction, output latch, edge-enable and alternate-function bit is zero. All pins are therefore inputs, pin_o and pin_oe_o are zero, and rdata_o, err_o, pin_chg_o, stat_clr_o and stat_rd_o are zero.
- R2: Register offsets use base B(b) = 4*b for banks 0 to 2 and B(3) = 0x100. Relative to that base:
  - level is at B+0x00
  - direction is at B+0x0C
  - output set is at B+0x18
  - output clear is at B+0x24
  - rising-edge enable is at B+0x30
  - falling-edge enable is at B+0x3C
  - edge status is at B+0x48
  - the lower alternate-function word is at 0x54+8*b and the upper one at 0x58+8*b.
- R3: A write to the direction register replaces it with the written word, and a read returns the stored word. Bit value 1 means output.
- R4: A write to the set register ORs the written word into the output latch. No latch bit is cleared.
- R5: A write to the clear register clears every latch bit whose written bit is 1. No latch bit is set.
- R6: Reads of the set and clear registers return zero.
- R7: A level read returns, per pin, the latch bit if the direction bit is 1 and the sampled input if it is 0. The input is sampled one clock before it is used. Writes to the level register have no effect.
- R8: pin_oe_o equals the direction bits, and pin_o equals latch AND direction.
- R9: pin_chg_o pulses for exactly one cycle, after the clock edge at which the driven value changes, and only on the bits whose driven value changed. A write of any other register leaves pin_chg_o zero.
- R10: The rising-enable, falling-enable and both alternate-function registers store the written word and read it back. The two enable masks appear on rise_en_o and fall_en_o.
- R11: A read of a bank's status register returns that bank's stat_i bits and pulses that bank's bit of stat_rd_o for one cycle. A write pulses the written word on that bank's slice of stat_clr_o for one cycle.
- R12: An access at offset 0x200 or above changes nothing, returns zero and does not raise err_o.
- R13: An access below 0x200 at an offset that is not in the map, including any offset with a nonzero low two bits, returns zero, changes nothing and raises err_o for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | BANK_W | Write data |
| rdata_o | output | BANK_W | Read data, valid the cycle after the request |
| err_o | output | 1 | Unmapped access below the window end, the cycle after the request |
| pin_i | input | 4*BANK_W | Pin input levels |
| pin_o | output | 4*BANK_W | Driven pin values |
| pin_oe_o | output | 4*BANK_W | Pin output enables (direction) |
| pin_chg_o | output | 4*BANK_W | One-cycle mask of pins whose driven value changed |
| rise_en_o | output | 4*BANK_W | Rising-edge enable masks |
| fall_en_o | output | 4*BANK_W | Falling-edge enable masks |
| stat_i | input | 4*BANK_W | Edge status bits from the edge-detection logic |
| stat_clr_o | output | 4*BANK_W | One-cycle clear mask from status writes |
| stat_rd_o | output | 4 | One-cycle per-bank status read strobe |

## Verification
Some properties are checked by the assertions on every cycle:
- a set write never clears a latch bit, and a clear write never sets one
- the driven value changes only after direction, set or clear writes
- set and clear reads return zero
- accesses beyond the window never raise the error flag
- unmapped in-window accesses always do

Other behaviour only the bench can show, by sweeping every byte offset of the window and comparing against its own arithmetic address map and register model:
- that each offset reaches the right bank and register
- the exact per-pin merge in level reads
- the exact masks on the change and clear outputs
- that an out-of-window write does not alias into a real register

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;
  localparam int NBANK     = 4;
  localparam int WIN_BYTES = 512;

  typedef enum logic [3:0] {
    K_NONE  = 4'd0,
    K_LEVEL = 4'd1,
    K_DIR   = 4'd2,
    K_SET   = 4'd3,
    K_CLR   = 4'd4,
    K_RISE  = 4'd5,
    K_FALL  = 4'd6,
    K_STAT  = 4'd7,
    K_AFLO  = 4'd8,
    K_AFHI  = 4'd9
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
  } reg_sel_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o,
  output logic              in_win_o
);
  logic [5:0] idx;
  logic       upper;

  assign idx      = addr_i[7:2];
  assign upper    = addr_i[8];
  assign in_win_o = addr_i < ADDR_W'(WIN_BYTES);

  // Low region: 7 kinds x 3 banks, then 8 alternate-function words.
  // Upper region: same kind stride, bank 3 only.
  always_comb begin
    sel_o.kind = K_NONE;
    sel_o.bank = 2'd0;
    if (in_win_o && addr_i[1:0] == 2'b00) begin
      if (!upper) begin
        if (idx < 6'd21) begin
          sel_o.kind = reg_kind_e'(4'(idx / 6'd3) + 4'd1);
          sel_o.bank = 2'(idx % 6'd3);
        end else if (idx < 6'd29) begin
          sel_o.kind = idx[0] ? K_AFLO : K_AFHI;
          sel_o.bank = 2'((idx - 6'd21) >> 1);
        end
      end else if (idx < 6'd21 && (idx % 6'd3) == 6'd0) begin
        sel_o.kind = reg_kind_e'(4'(idx / 6'd3) + 4'd1);
        sel_o.bank = 2'd3;
      end
    end
  end
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
  import gpio_regs_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_kind_e         kind_i,
  input  logic [BANK_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] in_i,
  input  logic [BANK_W-1:0] stat_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic [BANK_W-1:0] drv_o,
  output logic [BANK_W-1:0] oe_o,
  output logic [BANK_W-1:0] chg_o,
  output logic [BANK_W-1:0] rise_o,
  output logic [BANK_W-1:0] fall_o
);
  logic [BANK_W-1:0] dir_q, ol_q, rise_q, fall_q, aflo_q, afhi_q, drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      ol_q   <= '0;
      rise_q <= '0;
      fall_q <= '0;
      aflo_q <= '0;
      afhi_q <= '0;
      drv_q  <= '0;
    end else begin
      drv_q <= drv_o;
      if (wr_i) begin
        unique case (kind_i)
          K_DIR:   dir_q  <= wdata_i;
          K_SET:   ol_q   <= ol_q | wdata_i;
          K_CLR:   ol_q   <= ol_q & ~wdata_i;
          K_RISE:  rise_q <= wdata_i;
          K_FALL:  fall_q <= wdata_i;
          K_AFLO:  aflo_q <= wdata_i;
          K_AFHI:  afhi_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign drv_o  = ol_q & dir_q;
  assign oe_o   = dir_q;
  assign chg_o  = drv_o ^ drv_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  always_comb begin
    unique case (kind_i)
      K_LEVEL: rdata_o = (ol_q & dir_q) | (in_i & ~dir_q);
      K_DIR:   rdata_o = dir_q;
      K_RISE:  rdata_o = rise_q;
      K_FALL:  rdata_o = fall_q;
      K_AFLO:  rdata_o = aflo_q;
      K_AFHI:  rdata_o = afhi_q;
      K_STAT:  rdata_o = stat_i;
      default: rdata_o = '0;
    endcase
  end

  assert_set_no_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == K_SET) |=>
      ((ol_q & $past(wdata_i)) == $past(wdata_i)) && ((ol_q & $past(ol_q)) == $past(ol_q)));

  assert_clr_no_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && kind_i == K_CLR) |=>
      ((ol_q & $past(wdata_i)) == '0) && ((ol_q & ~$past(ol_q)) == '0));

  assert_chg_only_on_drive_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (kind_i == K_DIR || kind_i == K_SET || kind_i == K_CLR)) |=> chg_o == '0);

  assert_dir_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && kind_i == K_DIR) |=> $stable(oe_o));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_regs_pkg::*;
#(
  parameter int BANK_W = 32,
  parameter int ADDR_W = 12,
  localparam int PIN_N = NBANK * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  output logic              err_o,
  input  logic [PIN_N-1:0]  pin_i,
  output logic [PIN_N-1:0]  pin_o,
  output logic [PIN_N-1:0]  pin_oe_o,
  output logic [PIN_N-1:0]  pin_chg_o,
  output logic [PIN_N-1:0]  rise_en_o,
  output logic [PIN_N-1:0]  fall_en_o,
  input  logic [PIN_N-1:0]  stat_i,
  output logic [PIN_N-1:0]  stat_clr_o,
  output logic [NBANK-1:0]  stat_rd_o
);
  reg_sel_t          sel;
  logic              in_win, mapped;
  logic [PIN_N-1:0]  in_q;
  logic [BANK_W-1:0] rd_v [NBANK];

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .sel_o    (sel),
    .in_win_o (in_win)
  );

  assign mapped = sel.kind != K_NONE;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic wr_b;
    assign wr_b = req_i && we_i && mapped && sel.bank == 2'(b);

    gpio_bank_slice #(.BANK_W(BANK_W)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_b),
      .kind_i  (sel.kind),
      .wdata_i (wdata_i),
      .in_i    (in_q[b*BANK_W +: BANK_W]),
      .stat_i  (stat_i[b*BANK_W +: BANK_W]),
      .rdata_o (rd_v[b]),
      .drv_o   (pin_o[b*BANK_W +: BANK_W]),
      .oe_o    (pin_oe_o[b*BANK_W +: BANK_W]),
      .chg_o   (pin_chg_o[b*BANK_W +: BANK_W]),
      .rise_o  (rise_en_o[b*BANK_W +: BANK_W]),
      .fall_o  (fall_en_o[b*BANK_W +: BANK_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q       <= '0;
      rdata_o    <= '0;
      err_o      <= 1'b0;
      stat_clr_o <= '0;
      stat_rd_o  <= '0;
    end else begin
      in_q    <= pin_i;
      rdata_o <= (req_i && !we_i && mapped) ? rd_v[sel.bank] : '0;
      err_o   <= req_i && in_win && !mapped;
      for (int b = 0; b < NBANK; b++) begin
        stat_clr_o[b*BANK_W +: BANK_W] <=
          (req_i && we_i && sel.kind == K_STAT && sel.bank == 2'(b)) ? wdata_i : '0;
        stat_rd_o[b] <= req_i && !we_i && sel.kind == K_STAT && sel.bank == 2'(b);
      end
    end
  end

  assert_out_of_window_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !in_win) |=> (!err_o && rdata_o == '0));

  assert_unmapped_err_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && in_win && !mapped) |=> (err_o && rdata_o == '0));

  assert_err_needs_req_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(req_i));

  assert_wo_reads_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (sel.kind == K_SET || sel.kind == K_CLR)) |=> rdata_o == '0);

  assert_stat_rd_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(stat_rd_o));
endmodule

// File: tb/tb_gpio_bank_regs.sv
module tb_gpio_bank_regs;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 32;
  localparam int AW = 12;
  localparam int PN = 4 * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] wdata = '0;
  logic [BW-1:0] rdata;
  logic          err;
  logic [PN-1:0] pin_in, pin_out, pin_oe, pin_chg, rise_en, fall_en, stat_in, stat_clr;
  logic [3:0]    stat_rd;

  int total = 0, fails = 0;

  logic [BW-1:0] m_dir [4], m_ol [4], m_rise [4], m_fall [4], m_af [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_regs #(.BANK_W(BW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .pin_chg_o(pin_chg),
    .rise_en_o(rise_en), .fall_en_o(fall_en), .stat_i(stat_in),
    .stat_clr_o(stat_clr), .stat_rd_o(stat_rd)
  );

  task automatic chk(input string tag, input logic [PN-1:0] act, input logic [PN-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // returns kind*4+bank, or -1; kinds: 1 level,2 dir,3 set,4 clr,5 rise,6 fall,7 stat,8 aflo,9 afhi
  function automatic int lookup(input int off);
    for (int b = 0; b < 4; b++) begin
      int base;
      base = (b < 3) ? 4 * b : 'h100;
      for (int k = 0; k < 7; k++)
        if (off == base + 'h0C * k) return (k + 1) * 4 + b;
      if (off == 'h54 + 8 * b) return 8 * 4 + b;
      if (off == 'h58 + 8 * b) return 9 * 4 + b;
    end
    return -1;
  endfunction

  function automatic logic [BW-1:0] exp_read(input int off);
    int r, k, b;
    r = lookup(off);
    if (r < 0) return '0;
    k = r / 4; b = r % 4;
    case (k)
      1: return (m_ol[b] & m_dir[b]) | (pin_in[b*BW +: BW] & ~m_dir[b]);
      2: return m_dir[b];
      5: return m_rise[b];
      6: return m_fall[b];
      7: return stat_in[b*BW +: BW];
      8: return m_af[2*b];
      9: return m_af[2*b+1];
      default: return '0;
    endcase
  endfunction

  function automatic string rtag(input int off);
    int r;
    if (off >= 'h200) return "R12";
    r = lookup(off);
    if (r < 0) return "R13";
    case (r / 4)
      1: return "R2/R7";
      2: return "R2/R3";
      3, 4: return "R2/R6";
      7: return "R2/R11";
      default: return "R2/R10";
    endcase
  endfunction

  function automatic logic [PN-1:0] m_drive();
    logic [PN-1:0] v;
    for (int b = 0; b < 4; b++) v[b*BW +: BW] = m_ol[b] & m_dir[b];
    return v;
  endfunction

  function automatic logic [PN-1:0] m_oe();
    logic [PN-1:0] v;
    for (int b = 0; b < 4; b++) v[b*BW +: BW] = m_dir[b];
    return v;
  endfunction

  function automatic logic [PN-1:0] m_en(input bit fall);
    logic [PN-1:0] v;
    for (int b = 0; b < 4; b++) v[b*BW +: BW] = fall ? m_fall[b] : m_rise[b];
    return v;
  endfunction

  task automatic model_write(input int off, input logic [BW-1:0] d);
    int r, b;
    r = lookup(off);
    if (r < 0) return;
    b = r % 4;
    case (r / 4)
      2: m_dir[b] = d;
      3: m_ol[b] = m_ol[b] | d;
      4: m_ol[b] = m_ol[b] & ~d;
      5: m_rise[b] = d;
      6: m_fall[b] = d;
      8: m_af[2*b] = d;
      9: m_af[2*b+1] = d;
      default: ;
    endcase
  endtask

  task automatic bus(input bit w, input int a, input logic [BW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_write(input int off, input logic [BW-1:0] d);
    logic [PN-1:0] old_drv, exp_clr;
    int r;
    old_drv = m_drive();
    model_write(off, d);
    r = (off < 'h200) ? lookup(off) : -1;
    exp_clr = '0;
    if (r >= 0 && r / 4 == 7) exp_clr[(r % 4)*BW +: BW] = d;
    bus(1'b1, off, d);
    chk({rtag(off), " write err"}, PN'(err), PN'(off < 'h200 && r < 0));
    chk("R8 pin_oe", pin_oe, m_oe());
    chk("R4/R5/R8 pin_o", pin_out, m_drive());
    chk("R9 chg mask", pin_chg, old_drv ^ m_drive());
    chk("R11 stat_clr", stat_clr, exp_clr);
    chk("R10 rise_en", rise_en, m_en(1'b0));
    chk("R10 fall_en", fall_en, m_en(1'b1));
  endtask

  task automatic do_read(input int off);
    int r;
    logic [3:0] exp_rd;
    r = (off < 'h200) ? lookup(off) : -1;
    exp_rd = '0;
    if (r >= 0 && r / 4 == 7) exp_rd[r % 4] = 1'b1;
    bus(1'b0, off, '0);
    chk({rtag(off), " rdata"}, PN'(rdata), PN'(off < 'h200 ? exp_read(off) : '0));
    chk({rtag(off), " read err"}, PN'(err), PN'(off < 'h200 && r < 0));
    chk("R11 stat_rd", PN'(stat_rd), PN'(exp_rd));
    chk("R9 chg idle", pin_chg, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    pin_in  = {32'hC3A5_1E0F, 32'h0FF0_0FF0, 32'h1234_5678, 32'h9BDF_0246};
    stat_in = {32'h8000_0001, 32'h00FF_0000, 32'h5555_AAAA, 32'h0000_F00D};
    for (int b = 0; b < 4; b++) begin
      m_dir[b] = '0; m_ol[b] = '0; m_rise[b] = '0; m_fall[b] = '0;
    end
    for (int i = 0; i < 8; i++) m_af[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1 rdata", PN'(rdata), '0);
    chk("R1 err", PN'(err), '0);
    chk("R1 pin_o", pin_out, '0);
    chk("R1 pin_oe", pin_oe, '0);
    chk("R1 chg", pin_chg, '0);
    chk("R1 rise/fall", rise_en | fall_en, '0);
    chk("R1 stat_clr", stat_clr, '0);

    // R1/R2: every byte offset read after reset
    for (int off = 0; off < 'h200; off++) do_read(off);

    // write-then-read sweep of every byte offset
    for (int off = 0; off < 'h200; off++) begin
      do_write(off, 32'(off) * 32'h9E37_79B1 ^ 32'h5A5A_0F0F);
      do_read(off);
    end

    // re-read to catch cross-offset aliasing
    for (int off = 0; off < 'h200; off++) do_read(off);

    // R12: out-of-window accesses, including aliases of mapped offsets
    do_write('h200, '1);
    do_write('h20C, '1);
    do_write('h318, '1);
    do_write('hFFC, '1);
    do_write('h348, '1);
    do_read('h200);
    do_read('h30C);
    do_read('hFFC);
    do_read('h00C);
    do_read('h10C);

    // R4/R5/R9: targeted drive changes on bank 2
    do_write('h014, 32'hFFFF_0000);
    do_write('h02C, 32'hFFFF_FFFF);
    do_write('h020, 32'h000F_00F0);
    do_write('h020, 32'h000F_00F0);
    do_write('h02C, 32'h0003_0000);
    do_write('h014, 32'h0000_FFFF);
    do_read('h008);
    // R7: level write ignored
    do_write('h100, '1);
    do_read('h100);
    // R5: clear with zero changes nothing
    do_write('h124, '0);
    do_read('h100);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule